// File: doc/BRIEF.md
# Long-Call Pair Sequencer

This block carries out a long subroutine call that the instruction set splits across two consecutive 16-bit halfwords. The leading half holds the upper part of the branch offset, and the trailing half holds the lower part. Each cycle that `in_valid` is high, the block takes one fetch word together with three context values. It picks the current and the following halfword out of the fetch word, using the configured byte order. It then classifies both halfwords and works out the register updates that the call sequence produces.

There are three cases. If the leading half is followed at once by its trailing half, the two are fused into one step that consumes two halfwords. A leading half seen alone only updates the link register, which then holds the intermediate target. A trailing half seen alone finishes the call from whatever value the link register already holds. Every result is registered and appears one cycle after the request. A write-enable goes with each new value, and a flush pulse tells the front end to discard prefetched instructions whenever the program counter is redirected.

Register storage and instruction fetch belong to the surrounding pipeline. This block only computes the updates and reports how many halfwords it consumed.

Top module: `lcall_seq`

## Requirements
- R1: With `big_endian`=1 the current halfword is `fetch_word[31:16]` and the following halfword is `fetch_word[15:0]`; with `big_endian`=0 the two lanes swap.
- R2: A current halfword whose bits [15:11] are 11110 and whose following halfword is not a trailing half produces `link_wr`=1, `link_out` = `pc_view` + (bits [10:0] sign-extended from bit 10, shifted left by 12), `pc_wr`=0, `out_is_call`=1 and `consumed`=1.
- R3: A current halfword whose bits [15:11] are 11111 produces `pc_wr`=1 and `pc_out` = `link_in` + (bits [10:0] zero-extended, shifted left by 1), with `consumed`=1.
- R4: For a lone trailing half, `link_wr`=1 and `link_out` = `insn_addr` + 2 with bit 0 forced to 1.
- R5: A leading half followed by a trailing half (bits [15:11] = 11111) is fused. `pc_out` = (the R2 link value) + (trailing offset shifted left by 1), `link_out` = (`insn_addr` + 4) with bit 0 forced to 1, both write-enables are 1, and `consumed`=2.
- R6: `flush` is 1 exactly when `pc_wr` is 1, and never without `out_valid`.
- R7: Any other current halfword gives `out_is_call`=0, `link_wr`=0, `pc_wr`=0 and `consumed`=1. A value output whose write-enable is 0 reads zero.
- R8: `out_valid` is 1 in the cycle after a cycle with `in_valid`=1 and 0 otherwise. A cycle with `in_valid`=0 produces no writes.
- R9: While `rst_n` is low at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| fetch_word | input | 32 | Two halfwords as fetched |
| big_endian | input | 1 | Lane order of the fetch word |
| insn_addr | input | 32 | Address of the current halfword |
| pc_view | input | 32 | Program-counter value seen by the current halfword |
| link_in | input | 32 | Present link register value |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_is_call | output | 1 | Current halfword was part of a call pair |
| link_wr | output | 1 | Link register write-enable |
| link_out | output | 32 | New link register value |
| pc_wr | output | 1 | Program-counter write-enable |
| pc_out | output | 32 | New program counter value |
| flush | output | 1 | Discard prefetched instructions |
| consumed | output | 2 | Halfwords consumed (1 or 2) |

## Verification
The assertions assume that `rst_n` is held low over at least one clock edge before any request, and that requests are presented only as a single-cycle `in_valid` level sampled at the rising edge. They make no assumption about the values of the halfwords. The stimulus changes inputs only on the falling edge and starts requests only after reset has been released. It mixes leading, trailing and unrelated halfwords in both lane orders, including offsets with bit 10 set, and adds idle cycles between requests.

// File: rtl/lcall_pkg.sv
// Package: shared kinds and widths for the long-call pair sequencer.
// Assumes 16-bit halfwords with an 11-bit offset field in bits [10:0].
package lcall_pkg;
    localparam int HW_W   = 16;
    localparam int OFF_W  = 11;
    localparam int TAG_W  = HW_W - OFF_W;

    localparam logic [TAG_W-1:0] TAG_LEAD  = 5'b11110;
    localparam logic [TAG_W-1:0] TAG_TRAIL = 5'b11111;

    typedef enum logic [1:0] {
        HK_OTHER = 2'd0,
        HK_LEAD  = 2'd1,
        HK_TRAIL = 2'd2
    } hw_kind_e;
endpackage

// File: rtl/lcall_halfsel.sv
// Module: lcall_halfsel
// Splits a fetch word into the current and following halfwords.
// Assumes FETCH_W is exactly twice the halfword width.
module lcall_halfsel #(
    parameter int FETCH_W = 32
) (
    input  logic [FETCH_W-1:0]   fetch_word,
    input  logic                 big_endian,
    output logic [FETCH_W/2-1:0] cur_hw,
    output logic [FETCH_W/2-1:0] nxt_hw
);
    localparam int HALF = FETCH_W / 2;

    logic [HALF-1:0] upper_lane;
    logic [HALF-1:0] lower_lane;

    // Lane extraction from the fetch word.
    always_comb begin
        upper_lane = fetch_word[FETCH_W-1:HALF];
        lower_lane = fetch_word[HALF-1:0];
    end

    // Byte-order selection of current versus following halfword.
    always_comb begin
        if (big_endian) begin
            cur_hw = upper_lane;
            nxt_hw = lower_lane;
        end else begin
            cur_hw = lower_lane;
            nxt_hw = upper_lane;
        end
    end
endmodule

// File: rtl/lcall_classify.sv
// Module: lcall_classify
// Identifies a halfword as leading call half, trailing call half or other,
// and extracts its offset field. Purely combinational.
module lcall_classify
    import lcall_pkg::*;
(
    input  logic [HW_W-1:0]  hw,
    output hw_kind_e         kind,
    output logic [OFF_W-1:0] offset
);
    logic [TAG_W-1:0] tag;

    // Field split into tag and offset.
    always_comb begin
        tag    = hw[HW_W-1:OFF_W];
        offset = hw[OFF_W-1:0];
    end

    // Tag decode to halfword kind.
    always_comb begin
        if (tag == TAG_LEAD)       kind = HK_LEAD;
        else if (tag == TAG_TRAIL) kind = HK_TRAIL;
        else                       kind = HK_OTHER;
    end
endmodule

// File: rtl/lcall_exec.sv
// Module: lcall_exec
// Computes link and program-counter updates for the long-call pair.
// Assumes ADDR_W >= OFF_W + 13 so the shifted leading offset fits.
module lcall_exec
    import lcall_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  hw_kind_e          cur_kind,
    input  logic [OFF_W-1:0]  cur_off,
    input  hw_kind_e          nxt_kind,
    input  logic [OFF_W-1:0]  nxt_off,
    input  logic [ADDR_W-1:0] insn_addr,
    input  logic [ADDR_W-1:0] pc_view,
    input  logic [ADDR_W-1:0] link_in,
    output logic              is_call,
    output logic              link_wr,
    output logic [ADDR_W-1:0] link_val,
    output logic              pc_wr,
    output logic [ADDR_W-1:0] pc_val,
    output logic [1:0]        consumed
);
    localparam int LEAD_SH  = 12;
    localparam int TRAIL_SH = 1;
    localparam int LEAD_EXT = ADDR_W - OFF_W - LEAD_SH;
    localparam int TRL_EXT  = ADDR_W - OFF_W - TRAIL_SH;

    logic [ADDR_W-1:0] lead_disp;
    logic [ADDR_W-1:0] cur_trail_disp;
    logic [ADDR_W-1:0] nxt_trail_disp;
    logic [ADDR_W-1:0] lead_link;
    logic [ADDR_W-1:0] trail_addr;
    logic              fused;

    // Offset scaling: leading half sign-extended, trailing zero-extended.
    always_comb begin
        lead_disp      = {{LEAD_EXT{cur_off[OFF_W-1]}}, cur_off, {LEAD_SH{1'b0}}};
        cur_trail_disp = {{TRL_EXT{1'b0}}, cur_off, {TRAIL_SH{1'b0}}};
        nxt_trail_disp = {{TRL_EXT{1'b0}}, nxt_off, {TRAIL_SH{1'b0}}};
    end

    // Intermediate link value and address of the trailing half.
    always_comb begin
        lead_link  = pc_view + lead_disp;
        fused      = (cur_kind == HK_LEAD) && (nxt_kind == HK_TRAIL);
        trail_addr = fused ? (insn_addr + ADDR_W'(2)) : insn_addr;
    end

    // Case selection for the final updates.
    always_comb begin
        is_call  = 1'b0;
        link_wr  = 1'b0;
        pc_wr    = 1'b0;
        link_val = '0;
        pc_val   = '0;
        consumed = 2'd1;
        if (fused) begin
            is_call  = 1'b1;
            link_wr  = 1'b1;
            pc_wr    = 1'b1;
            pc_val   = lead_link + nxt_trail_disp;
            link_val = (trail_addr + ADDR_W'(2)) | ADDR_W'(1);
            consumed = 2'd2;
        end else if (cur_kind == HK_LEAD) begin
            is_call  = 1'b1;
            link_wr  = 1'b1;
            link_val = lead_link;
        end else if (cur_kind == HK_TRAIL) begin
            is_call  = 1'b1;
            link_wr  = 1'b1;
            pc_wr    = 1'b1;
            pc_val   = link_in + cur_trail_disp;
            link_val = (trail_addr + ADDR_W'(2)) | ADDR_W'(1);
        end
    end
endmodule

// File: rtl/lcall_seq.sv
// Module: lcall_seq (top)
// Long-call pair sequencer: selects halfwords, classifies both, computes
// the updates and registers them with one cycle of latency.
// Assumes rst_n is synchronous and active low.
module lcall_seq
    import lcall_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FETCH_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FETCH_W-1:0] fetch_word,
    input  logic               big_endian,
    input  logic [ADDR_W-1:0]  insn_addr,
    input  logic [ADDR_W-1:0]  pc_view,
    input  logic [ADDR_W-1:0]  link_in,
    output logic               out_valid,
    output logic               out_is_call,
    output logic               link_wr,
    output logic [ADDR_W-1:0]  link_out,
    output logic               pc_wr,
    output logic [ADDR_W-1:0]  pc_out,
    output logic               flush,
    output logic [1:0]         consumed
);
    localparam int NUM_HW = 2;

    logic [HW_W-1:0]  hw_sel  [NUM_HW];
    hw_kind_e         hw_kind [NUM_HW];
    logic [OFF_W-1:0] hw_off  [NUM_HW];

    logic              c_is_call;
    logic              c_link_wr;
    logic [ADDR_W-1:0] c_link_val;
    logic              c_pc_wr;
    logic [ADDR_W-1:0] c_pc_val;
    logic [1:0]        c_consumed;

    lcall_halfsel #(.FETCH_W(FETCH_W)) u_halfsel (
        .fetch_word (fetch_word),
        .big_endian (big_endian),
        .cur_hw     (hw_sel[0]),
        .nxt_hw     (hw_sel[1])
    );

    // One classifier per halfword position (current, following).
    for (genvar gi = 0; gi < NUM_HW; gi++) begin : g_cls
        lcall_classify u_cls (
            .hw     (hw_sel[gi]),
            .kind   (hw_kind[gi]),
            .offset (hw_off[gi])
        );
    end

    lcall_exec #(.ADDR_W(ADDR_W)) u_exec (
        .cur_kind  (hw_kind[0]),
        .cur_off   (hw_off[0]),
        .nxt_kind  (hw_kind[1]),
        .nxt_off   (hw_off[1]),
        .insn_addr (insn_addr),
        .pc_view   (pc_view),
        .link_in   (link_in),
        .is_call   (c_is_call),
        .link_wr   (c_link_wr),
        .link_val  (c_link_val),
        .pc_wr     (c_pc_wr),
        .pc_val    (c_pc_val),
        .consumed  (c_consumed)
    );

    // Output register stage, qualified by the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_is_call <= 1'b0;
            link_wr     <= 1'b0;
            link_out    <= '0;
            pc_wr       <= 1'b0;
            pc_out      <= '0;
            flush       <= 1'b0;
            consumed    <= 2'd0;
        end else if (in_valid) begin
            out_valid   <= 1'b1;
            out_is_call <= c_is_call;
            link_wr     <= c_link_wr;
            link_out    <= c_link_val;
            pc_wr       <= c_pc_wr;
            pc_out      <= c_pc_val;
            flush       <= c_pc_wr;
            consumed    <= c_consumed;
        end else begin
            out_valid   <= 1'b0;
            out_is_call <= 1'b0;
            link_wr     <= 1'b0;
            link_out    <= '0;
            pc_wr       <= 1'b0;
            pc_out      <= '0;
            flush       <= 1'b0;
            consumed    <= 2'd0;
        end
    end

    AST_OUT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R8
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!link_wr && !pc_wr && !flush)); // R8
    AST_FLUSH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (out_valid && pc_wr)); // R6
    AST_FUSED_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && consumed == 2'd2) |-> (pc_wr && link_wr && out_is_call)); // R5
    AST_LINK_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pc_wr) |-> link_out[0]); // R4
    AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && link_wr && !pc_wr) |-> (consumed == 2'd1)); // R2
    AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_call) |-> (!link_wr && !pc_wr && consumed == 2'd1)); // R7
endmodule

// File: tb/lcall_seq_tb.sv
// Scoreboard bench for lcall_seq: the driver pushes one expected item per
// cycle, the monitor pops and compares one cycle after each push.
module lcall_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        big_endian = 1'b0;
    logic [31:0] insn_addr = '0;
    logic [31:0] pc_view = '0;
    logic [31:0] link_in = '0;
    logic        out_valid, out_is_call, link_wr, pc_wr, flush;
    logic [31:0] link_out, pc_out;
    logic [1:0]  consumed;

    int n_checks = 0;
    int n_fail   = 0;
    bit run_mon  = 1'b0;

    typedef struct {
        bit          v;
        bit          call;
        bit          lwr;
        bit          pwr;
        logic [31:0] lk;
        logic [31:0] pc;
        int          cons;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    lcall_seq dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fetch_word(fetch_word),
        .big_endian(big_endian), .insn_addr(insn_addr), .pc_view(pc_view),
        .link_in(link_in), .out_valid(out_valid), .out_is_call(out_is_call),
        .link_wr(link_wr), .link_out(link_out), .pc_wr(pc_wr), .pc_out(pc_out),
        .flush(flush), .consumed(consumed)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [15:0] cur, input logic [15:0] nxt,
                                   input logic [31:0] addr, input logic [31:0] pcv,
                                   input logic [31:0] lnk);
        exp_t e;
        logic signed [31:0] sdisp;
        logic [31:0] mid;
        e.v = 1; e.call = 0; e.lwr = 0; e.pwr = 0; e.lk = 0; e.pc = 0; e.cons = 1;
        sdisp = $signed({{21{cur[10]}}, cur[10:0]}) * 4096;
        if (cur[15:11] == 5'b11110 && nxt[15:11] == 5'b11111) begin
            mid = pcv + sdisp;
            e.call = 1; e.lwr = 1; e.pwr = 1; e.cons = 2;
            e.pc = mid + 32'(nxt[10:0]) * 2;
            e.lk = (addr + 4) | 32'd1;
            e.tag = "R5";
        end else if (cur[15:11] == 5'b11110) begin
            e.call = 1; e.lwr = 1;
            e.lk = pcv + sdisp;
            e.tag = "R2";
        end else if (cur[15:11] == 5'b11111) begin
            e.call = 1; e.lwr = 1; e.pwr = 1;
            e.pc = lnk + 32'(cur[10:0]) * 2;
            e.lk = (addr + 2) | 32'd1;
            e.tag = "R3";
        end else begin
            e.tag = "R7";
        end
        return e;
    endfunction

    // Driver: one request, expected item pushed in the same cycle.
    task automatic drive(input logic [15:0] cur, input logic [15:0] nxt, input bit be,
                         input logic [31:0] addr, input logic [31:0] pcv,
                         input logic [31:0] lnk, input string note);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        big_endian = be;
        fetch_word = be ? {cur, nxt} : {nxt, cur};
        insn_addr  = addr;
        pc_view    = pcv;
        link_in    = lnk;
        e = model(cur, nxt, addr, pcv, lnk);
        if (note != "") e.tag = {e.tag, "/", note};
        sb.push_back(e);
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        fetch_word = 32'hF800_F800;
        e.v = 0; e.call = 0; e.lwr = 0; e.pwr = 0; e.lk = 0; e.pc = 0; e.cons = 0;
        e.tag = "R8";
        sb.push_back(e);
    endtask

    // Monitor: compares results one cycle after each pushed item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (run_mon && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(out_valid == e.v, e.tag, "out_valid", 32'(out_valid), 32'(e.v));
                if (e.v) begin
                    chk(out_is_call == e.call && link_wr == e.lwr && pc_wr == e.pwr,
                        e.tag, "call/link_wr/pc_wr",
                        {29'd0, out_is_call, link_wr, pc_wr}, {29'd0, e.call, e.lwr, e.pwr});
                    chk(link_out == e.lk, e.tag, "link_out", link_out, e.lk);
                    chk(pc_out == e.pc, e.tag, "pc_out", pc_out, e.pc);
                    chk(32'(consumed) == 32'(e.cons), e.tag, "consumed",
                        32'(consumed), 32'(e.cons));
                    chk(flush == e.pwr, "R6", "flush", 32'(flush), 32'(e.pwr));
                end else begin
                    chk(!link_wr && !pc_wr && !flush, "R8", "idle writes",
                        {29'd0, link_wr, pc_wr, flush}, 32'd0);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R9: reset clears outputs.
        repeat (3) @(posedge clk);
        #1;
        chk(!out_valid && !flush && !link_wr && !pc_wr && link_out == 0 && pc_out == 0
            && consumed == 0, "R9", "reset state", {28'd0, out_valid, flush, link_wr, pc_wr}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run_mon = 1'b1;

        // R2: lone leading half, positive and negative offsets.
        drive(16'hF123, 16'h0000, 1'b1, 32'h1000, 32'h1004, 32'h0, "pos");
        drive(16'hF456, 16'h2000, 1'b0, 32'h2000, 32'h2004, 32'h0, "neg");
        drive(16'hF7FF, 16'hF000, 1'b1, 32'h10, 32'h14, 32'h0, "neg_lead_next");
        // R3 R4: lone trailing half with given link.
        drive(16'hF80A, 16'hF800, 1'b1, 32'h3000, 32'h3004, 32'h0040_0000, "alone");
        drive(16'hFFFF, 16'h1234, 1'b0, 32'h3FFE, 32'h4002, 32'h1, "max");
        // R5: fused pair, both lane orders (R1).
        drive(16'hF001, 16'hF804, 1'b1, 32'h4000, 32'h4004, 32'hDEAD, "R1_be");
        drive(16'hF001, 16'hF804, 1'b0, 32'h4000, 32'h4004, 32'hDEAD, "R1_le");
        drive(16'hF7FE, 16'hFFFF, 1'b1, 32'h8000, 32'h8004, 32'h0, "neg");
        // R1: swapped lanes make a trailing half current.
        drive(16'hF810, 16'hF001, 1'b0, 32'h500, 32'h504, 32'h9000, "R1_swap");
        // R7: unrelated halfwords.
        drive(16'h4770, 16'hF800, 1'b1, 32'h600, 32'h604, 32'h123, "");
        drive(16'hE7FE, 16'hF001, 1'b0, 32'h700, 32'h704, 32'h0, "");
        idle();
        drive(16'hF000, 16'hF800, 1'b1, 32'hFFFF_FFFC, 32'h0, 32'h0, "wrap");
        idle();
        idle();

        // Mixed stream with bubbles.
        for (int i = 0; i < 400; i++) begin
            logic [15:0] hw [2];
            for (int k = 0; k < 2; k++) begin
                int sel;
                sel = $urandom_range(0, 2);
                if (sel == 0)      hw[k] = {5'b11110, 11'($urandom)};
                else if (sel == 1) hw[k] = {5'b11111, 11'($urandom)};
                else               hw[k] = {1'b0, 15'($urandom)};
            end
            if ($urandom_range(0, 5) == 0) idle();
            else drive(hw[0], hw[1], 1'($urandom), {$urandom} & 32'hFFFF_FFFE,
                       $urandom, $urandom, "mix");
        end
        idle();
        idle();
        @(posedge clk);
        #2;
        chk(sb.size() == 0, "R8", "scoreboard drained", 32'(sb.size()), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule